// File: doc/BRIEF.md
# Post-Update Shifted-Address Load Unit

This execute-stage unit runs one family of integer loads on a 64-bit register machine. The access address is not the usual base-plus-index sum. It is the base register value shifted left by one to four bit positions, chosen by a 2-bit shift field. The index register is used only afterwards: the base register is rewritten with base plus index. The unit reads one aligned doubleword from a simple data-memory port. It picks out the addressed byte, halfword, word or doubleword in big-endian lane order, then applies zero or sign fill.

Decoded operations arrive on a valid/ready stream. An operation is taken on a cycle where `op_valid` and `op_ready` are both high. `op_ready` stays low from the cycle after acceptance until the load's writebacks have been presented, so only one load is in flight at a time. The memory request is a valid/ready pair. Once `mem_req_valid` rises, it holds with a stable address until `mem_req_ready` is seen. The response carries no back-pressure: the unit takes `mem_rsp_valid` as soon as it comes. On that cycle it presents both register writebacks, to the destination and to the base register, for one cycle. A base register number of zero, or one equal to the destination number, is an invalid form. Such an operation raises `illegal` and causes no memory traffic and no writeback.

Top module: `shupd_load_unit`

## Requirements
- R1: The memory request address equals `op_base` shifted left by (`op_sh`+1) bit positions, with bits shifted past bit 63 discarded. `op_index` has no effect on the address.
- R2: `wb_ra_data` equals (`op_base` + `op_index`) modulo 2^64, and `wb_ra_idx` equals `op_ra`.
- R3: Size code 0 (byte) places the addressed byte in bits 7:0 and clears bits 63:8, whatever `op_signed` is.
- R4: Size code 1 (halfword) places the 16 loaded bits in bits 15:0. Bits 63:16 are zero when `op_signed`=0 and copies of loaded bit 15 when `op_signed`=1.
- R5: Size code 2 (word) places the 32 loaded bits in bits 31:0. Bits 63:32 are zero when `op_signed`=0 and copies of loaded bit 31 when `op_signed`=1.
- R6: Size code 3 (doubleword) returns the 64 loaded bits unchanged, and `op_signed` has no effect.
- R7: Lane selection is big-endian. Byte offset 0 of the returned doubleword is bits 63:56. The offset is the low 3 address bits rounded down to a multiple of the access size.
- R8: An operation with `op_ra`=0 or `op_ra`=`op_rt` raises `illegal` for exactly the one cycle after acceptance. It issues no memory request and produces no writeback, and `busy` stays low.
- R9: `op_ready` is low while `busy` is high, so `op_valid` is ignored then. While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with the same address on the next cycle.
- R10: `wb_rt_valid` and `wb_ra_valid` are high together only in the cycle in which `mem_rsp_valid` arrives for an issued request, and `busy` is low on the following cycle. `wb_rt_idx` equals `op_rt`.
- R11: After reset, `busy`, `mem_req_valid`, `illegal` and both writeback valids are low, and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit can take an operation |
| op_base | input | 64 | Base register value |
| op_index | input | 64 | Index register value |
| op_ra | input | 5 | Base register number |
| op_rt | input | 5 | Destination register number |
| op_sh | input | 2 | Shift field; shift amount is value+1 |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_signed | input | 1 | 1 selects sign fill for halfword/word |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Effective byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Aligned doubleword holding the address |
| wb_rt_valid | output | 1 | Destination writeback strobe |
| wb_rt_idx | output | 5 | Destination register number |
| wb_rt_data | output | 64 | Extended load result |
| wb_ra_valid | output | 1 | Base register update strobe |
| wb_ra_idx | output | 5 | Base register number |
| wb_ra_data | output | 64 | Base plus index |
| illegal | output | 1 | Invalid-form pulse |
| busy | output | 1 | A load is in flight |

## Verification
The main function is driven through every size and fill-mode pairing, using response words whose upper bytes have the top bit set or clear. This separates zero fill from sign fill and catches a wrong fill width. Base values are chosen so that the computed address lands on each lane offset. One word access is misaligned inside its doubleword, which shows whether the offset is rounded down to the access size. A base with high bits set and the largest shift shows that overflow is truncated. Index values that are negative or that carry out of bit 63 show that the index only changes the post-update sum and never the address. Request stalls, response latencies of one to three cycles, an operation offered while busy, and both invalid-form cases test the handshake rules.

// File: rtl/pul_pkg.sv
package pul_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/pul_ea_gen.sv
module pul_ea_gen #(
  parameter int XLEN = 64,
  parameter int SHW  = 2
) (
  input  logic [XLEN-1:0] base,
  input  logic [SHW-1:0]  sh,
  output logic [XLEN-1:0] ea
);
  localparam int AMTW = SHW + 1;

  logic [AMTW-1:0] amt;

  // shift amount is field + 1; extra bit avoids wrap at the top value
  assign amt = AMTW'(sh) + AMTW'(1);
  assign ea  = base << amt;
endmodule

// File: rtl/pul_lane_extract.sv
module pul_lane_extract
  import pul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         dword,
  input  logic [$clog2(XLEN/8)-1:0] off,
  input  acc_size_e               size,
  input  logic                    sgn,
  output logic [XLEN-1:0]         res
);
  localparam int NBYTES = XLEN / 8;
  localparam int OFFW   = $clog2(NBYTES);

  logic [7:0]      lane [NBYTES];
  logic [XLEN-1:0] raw;
  logic            msb;
  logic            fill_sign;

  // big-endian lane numbering: lane 0 is the most significant byte
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = dword[XLEN-1-8*g -: 8];
  end

  assign fill_sign = sgn && (size == SZ_HALF || size == SZ_WORD);

  always_comb begin
    int nb;
    int base_off;
    nb       = 1 << int'(size);
    base_off = int'(off) & ~(nb - 1);
    raw      = '0;
    msb      = 1'b0;
    for (int i = 0; i < NBYTES; i++) begin
      if (i < nb) begin
        raw[8*i +: 8] = lane[OFFW'(base_off + nb - 1 - i)];
        if (i == nb - 1) msb = raw[8*i+7];
      end
    end
    res = raw;
    for (int i = 0; i < NBYTES; i++) begin
      if (i >= nb) res[8*i +: 8] = {8{fill_sign & msb}};
    end
  end
endmodule

// File: rtl/pul_ctrl.sv
module pul_ctrl
  import pul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [XLEN-1:0] ea_in,
  input  logic [XLEN-1:0] base_in,
  input  logic [XLEN-1:0] index_in,
  input  logic [REGW-1:0] ra_in,
  input  logic [REGW-1:0] rt_in,
  input  acc_size_e       size_in,
  input  logic            sgn_in,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] ea_q,
  input  logic            mem_rsp_valid,
  output logic            wb_fire,
  output logic [XLEN-1:0] sum_q,
  output logic [REGW-1:0] ra_q,
  output logic [REGW-1:0] rt_q,
  output acc_size_e       size_q,
  output logic            sgn_q,
  output logic            illegal,
  output logic            busy
);
  ctl_state_e state_q, state_d;
  logic       accept;
  logic       bad_form;
  logic       ill_q;

  assign op_ready      = (state_q == ST_IDLE);
  assign accept        = op_valid && op_ready;
  assign bad_form      = (ra_in == '0) || (ra_in == rt_in);
  assign mem_req_valid = (state_q == ST_REQ);
  assign wb_fire       = (state_q == ST_WAIT) && mem_rsp_valid;
  assign busy          = (state_q != ST_IDLE);
  assign illegal       = ill_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && !bad_form) state_d = ST_REQ;
      ST_REQ:  if (mem_req_ready)       state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid)       state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ill_q   <= accept && bad_form;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q   <= '0;
      sum_q  <= '0;
      ra_q   <= '0;
      rt_q   <= '0;
      size_q <= SZ_BYTE;
      sgn_q  <= 1'b0;
    end else if (accept && !bad_form) begin
      ea_q   <= ea_in;
      sum_q  <= base_in + index_in;
      ra_q   <= ra_in;
      rt_q   <= rt_in;
      size_q <= size_in;
      sgn_q  <= sgn_in;
    end
  end
endmodule

// File: rtl/shupd_load_unit.sv
module shupd_load_unit
  import pul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int SHW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [XLEN-1:0] op_base,
  input  logic [XLEN-1:0] op_index,
  input  logic [REGW-1:0] op_ra,
  input  logic [REGW-1:0] op_rt,
  input  logic [SHW-1:0]  op_sh,
  input  logic [1:0]      op_size,
  input  logic            op_signed,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            wb_rt_valid,
  output logic [REGW-1:0] wb_rt_idx,
  output logic [XLEN-1:0] wb_rt_data,
  output logic            wb_ra_valid,
  output logic [REGW-1:0] wb_ra_idx,
  output logic [XLEN-1:0] wb_ra_data,
  output logic            illegal,
  output logic            busy
);
  localparam int OFFW = $clog2(XLEN / 8);

  logic [XLEN-1:0] ea_c;
  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] sum_q;
  logic [REGW-1:0] ra_q;
  logic [REGW-1:0] rt_q;
  acc_size_e       size_q;
  logic            sgn_q;
  logic            wb_fire;

  pul_ea_gen #(.XLEN(XLEN), .SHW(SHW)) u_ea (
    .base (op_base),
    .sh   (op_sh),
    .ea   (ea_c)
  );

  pul_ctrl #(.XLEN(XLEN), .REGW(REGW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_ready      (op_ready),
    .ea_in         (ea_c),
    .base_in       (op_base),
    .index_in      (op_index),
    .ra_in         (op_ra),
    .rt_in         (op_rt),
    .size_in       (acc_size_e'(op_size)),
    .sgn_in        (op_signed),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .ea_q          (ea_q),
    .mem_rsp_valid (mem_rsp_valid),
    .wb_fire       (wb_fire),
    .sum_q         (sum_q),
    .ra_q          (ra_q),
    .rt_q          (rt_q),
    .size_q        (size_q),
    .sgn_q         (sgn_q),
    .illegal       (illegal),
    .busy          (busy)
  );

  pul_lane_extract #(.XLEN(XLEN)) u_lane (
    .dword (mem_rsp_data),
    .off   (ea_q[OFFW-1:0]),
    .size  (size_q),
    .sgn   (sgn_q),
    .res   (wb_rt_data)
  );

  assign mem_req_addr = ea_q;
  assign wb_rt_valid  = wb_fire;
  assign wb_ra_valid  = wb_fire;
  assign wb_rt_idx    = rt_q;
  assign wb_ra_idx    = ra_q;
  assign wb_ra_data   = sum_q;
endmodule

// File: rtl/shupd_load_unit_chk.sv
module shupd_load_unit_chk #(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int SHW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic [XLEN-1:0] op_base,
  input logic [REGW-1:0] op_ra,
  input logic [REGW-1:0] op_rt,
  input logic [SHW-1:0]  op_sh,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            wb_rt_valid,
  input logic            wb_ra_valid,
  input logic [REGW-1:0] wb_ra_idx,
  input logic            illegal,
  input logic            busy
);
  logic take_good;
  logic take_bad;
  assign take_good = op_valid && op_ready && op_ra != '0 && op_ra != op_rt;
  assign take_bad  = op_valid && op_ready && (op_ra == '0 || op_ra == op_rt);

  AST_EA_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    take_good |=> mem_req_valid &&
      mem_req_addr == ($past(op_base) << ({1'b0, $past(op_sh)} + 3'd1))); // R1

  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> illegal && !mem_req_valid && !busy); // R8

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_rt_valid && !wb_ra_valid && !mem_req_valid); // R8

  AST_WB_BASE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ra_valid |-> wb_ra_idx != '0); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_ready); // R9

  AST_WB_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_rt_valid |-> mem_rsp_valid && wb_ra_valid); // R10

  AST_WB_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_rt_valid |=> !busy && !wb_rt_valid); // R10
endmodule

bind shupd_load_unit shupd_load_unit_chk #(.XLEN(XLEN), .REGW(REGW), .SHW(SHW)) u_chk (.*);

// File: tb/shupd_load_unit_tb.sv
module shupd_load_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] idx;
    logic [4:0]  ra;
    logic [4:0]  rt;
    logic [1:0]  sh;
    logic [1:0]  sz;
    logic        sgn;
    logic [63:0] md;
    logic [63:0] exp_ea;
    logic [63:0] exp_rt;
    logic [1:0]  stall;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R3 byte at offset 0
    '{64'h10, 64'h8, 5'd3, 5'd4, 2'd0, 2'd0, 1'b0, 64'h0123456789ABCDEF,
      64'h20, 64'h01, 2'd0, 2'd1},
    // R3 R7 byte at offset 4
    '{64'h13, 64'h100, 5'd5, 5'd6, 2'd1, 2'd0, 1'b0, 64'h0123456789ABCDEF,
      64'h4C, 64'h89, 2'd1, 2'd2},
    // R4 halfword sign fill, R2 negative index
    '{64'h3, 64'hFFFFFFFFFFFFFFFF, 5'd7, 5'd8, 2'd0, 2'd1, 1'b1, 64'h0123456789ABCDEF,
      64'h6, 64'hFFFFFFFFFFFFCDEF, 2'd0, 2'd3},
    // R4 halfword zero fill
    '{64'h2, 64'h4, 5'd9, 5'd1, 2'd0, 2'd1, 1'b0, 64'h0123456789ABCDEF,
      64'h4, 64'h89AB, 2'd2, 2'd1},
    // R5 word sign fill
    '{64'h20, 64'h30, 5'd2, 5'd3, 2'd2, 2'd2, 1'b1, 64'h89ABCDEF01234567,
      64'h100, 64'hFFFFFFFF89ABCDEF, 2'd0, 2'd1},
    // R5 word zero fill
    '{64'h2, 64'h7, 5'd10, 5'd11, 2'd0, 2'd2, 1'b0, 64'h0123456789ABCDEF,
      64'h4, 64'h0000000089ABCDEF, 2'd1, 2'd1},
    // R5 word sign fill with positive top bit
    '{64'h1, 64'h1, 5'd12, 5'd13, 2'd1, 2'd2, 1'b1, 64'hFFFFFFFF7FFF0001,
      64'h4, 64'h7FFF0001, 2'd0, 2'd2},
    // R1 R6 doubleword, largest shift drops high bits, R2 sum wraps
    '{64'hF000000000000001, 64'h1000000000000000, 5'd31, 5'd30, 2'd3, 2'd3, 1'b1,
      64'hFEDCBA9876543210, 64'h10, 64'hFEDCBA9876543210, 2'd0, 2'd1},
    // R7 misaligned word rounded down to offset 0
    '{64'h1, 64'h2, 5'd14, 5'd15, 2'd0, 2'd2, 1'b0, 64'h0123456789ABCDEF,
      64'h2, 64'h01234567, 2'd0, 2'd1},
    // R3 byte ignores sign mode
    '{64'h2, 64'h0, 5'd16, 5'd17, 2'd0, 2'd0, 1'b1, 64'h0123456789ABCDEF,
      64'h4, 64'h89, 2'd0, 2'd1},
    // R4 R7 halfword at offset 6 with sign clear
    '{64'h3, 64'h5, 5'd18, 5'd19, 2'd0, 2'd1, 1'b1, 64'hFFFFFFFFFFFF1234,
      64'h6, 64'h1234, 2'd1, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [63:0] op_base = '0;
  logic [63:0] op_index = '0;
  logic [4:0]  op_ra = '0;
  logic [4:0]  op_rt = '0;
  logic [1:0]  op_sh = '0;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        wb_rt_valid;
  logic [4:0]  wb_rt_idx;
  logic [63:0] wb_rt_data;
  logic        wb_ra_valid;
  logic [4:0]  wb_ra_idx;
  logic [63:0] wb_ra_data;
  logic        illegal;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shupd_load_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready),
    .op_base(op_base), .op_index(op_index), .op_ra(op_ra), .op_rt(op_rt),
    .op_sh(op_sh), .op_size(op_size), .op_signed(op_signed),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_rt_valid(wb_rt_valid), .wb_rt_idx(wb_rt_idx), .wb_rt_data(wb_rt_data),
    .wb_ra_valid(wb_ra_valid), .wb_ra_idx(wb_ra_idx), .wb_ra_data(wb_ra_data),
    .illegal(illegal), .busy(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_op(input logic [63:0] b, input logic [63:0] x, input logic [4:0] ra,
                          input logic [4:0] rt, input logic [1:0] sh, input logic [1:0] sz,
                          input logic sg);
    @(negedge clk);
    op_valid = 1'b1; op_base = b; op_index = x; op_ra = ra; op_rt = rt;
    op_sh = sh; op_size = sz; op_signed = sg;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit offer_busy);
    drive_op(v.base, v.idx, v.ra, v.rt, v.sh, v.sz, v.sgn);
    chk("R1 request valid", 64'(mem_req_valid), 64'd1);
    chk("R1 address", mem_req_addr, v.exp_ea);
    if (offer_busy) begin
      op_valid = 1'b1; op_base = 64'hDEAD; op_ra = 5'd1; op_rt = 5'd2;
      chk("R9 not ready while busy", 64'(op_ready), 64'd0);
    end
    for (int s = 0; s < int'(v.stall); s++) begin
      mem_req_ready = 1'b0;
      @(negedge clk);
      chk("R9 request held", 64'(mem_req_valid), 64'd1);
      chk("R9 address stable", mem_req_addr, v.exp_ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int l = 1; l < int'(v.lat); l++) begin
      chk("R10 no early writeback", 64'(wb_rt_valid | wb_ra_valid), 64'd0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = v.md;
    #1;
    chk("R10 both writebacks", 64'({wb_rt_valid, wb_ra_valid}), 64'd3);
    chk("R3-R7 load data", wb_rt_data, v.exp_rt);
    chk("R10 dest index", 64'(wb_rt_idx), 64'(v.rt));
    chk("R2 base update", wb_ra_data, v.base + v.idx);
    chk("R2 base index", 64'(wb_ra_idx), 64'(v.ra));
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    op_valid = 1'b0;
    chk("R10 idle after writeback", 64'({busy, wb_rt_valid}), 64'd0);
    @(negedge clk);
    chk("R9 busy op ignored", 64'(mem_req_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 busy", 64'(busy), 64'd0);
    chk("R11 op_ready", 64'(op_ready), 64'd1);
    chk("R11 req", 64'(mem_req_valid), 64'd0);
    chk("R11 illegal", 64'(illegal), 64'd0);
    chk("R11 writebacks", 64'({wb_rt_valid, wb_ra_valid}), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R9 an operation offered while busy is not taken
    run_vec(VECS[3], 1'b1);

    // R8 base register zero
    drive_op(64'h40, 64'h1, 5'd0, 5'd4, 2'd0, 2'd3, 1'b0);
    chk("R8 illegal ra zero", 64'(illegal), 64'd1);
    chk("R8 no request ra zero", 64'(mem_req_valid), 64'd0);
    chk("R8 not busy", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R8 pulse one cycle", 64'(illegal), 64'd0);
    chk("R8 still no request", 64'(mem_req_valid), 64'd0);

    // R8 base equals destination
    drive_op(64'h40, 64'h1, 5'd9, 5'd9, 2'd1, 2'd2, 1'b1);
    chk("R8 illegal ra eq rt", 64'(illegal), 64'd1);
    chk("R8 no writeback", 64'({wb_rt_valid, wb_ra_valid, mem_req_valid}), 64'd0);
    @(negedge clk);
    chk("R8 pulse ends", 64'(illegal), 64'd0);

    // legal op directly after illegal ones still works
    run_vec(VECS[7], 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule